// File: doc/BRIEF.md
# Sequence-Number Reordering Jitter Buffer

This block sits between the packet receive path and a constant-rate TDM transmit port. Each accepted pseudowire packet carries a 16-bit sequence number and a fixed-size payload. The whole payload is written in one cycle into one of 16 slots, and the slot is chosen by the sequence number modulo 16. The TDM side pulls one byte per timeslot tick. For every request it gets back a byte and two flags. One flag says the byte is missing and must be replaced downstream. The other says the missing byte was caused by the buffer running dry rather than by a single lost packet.

Two configuration inputs set how sequence numbers are used. One chooses which header field supplies the number: the control word or the RTP header. The other chooses how late packets are handled. With reordering on, a late packet is still placed in its slot as long as its slot has not yet been played out. With reordering off, any packet that is not newer than the newest packet already accepted is dropped. A third input sets how many slots must hold data before playout starts. Playout also waits for that count again after every underrun.

The playout controller has three states. `ST_IDLE` is the state after reset, with no read position yet. `ST_FILL` waits for the prefill count. `ST_PLAY` drains the slots in order. It has three transitions. T_ANCHOR (`ST_IDLE`→`ST_FILL`) is taken on the first packet, whose number becomes the read position. T_PRIMED (`ST_FILL`→`ST_PLAY`) is taken once the number of filled slots reaches the prefill count. T_UNDERRUN (`ST_PLAY`→`ST_FILL`) is taken when a slot starts playing while the whole buffer is empty.

Top module: `seq_jitter_buf`

## Requirements
- R1: When `cfg_seq_src`=1 the sequence number is taken from `wr_rtp_seq`; when it is 0 it is taken from `wr_cw_seq`. The field that is not selected has no effect.
- R2: An accepted packet goes into slot (sequence mod 16). Slots are played in ascending sequence order. Within a slot, payload byte k is `wr_payload[8k+7:8k]`, and byte 0 is played first.
- R3: Every `rd_req` is answered exactly one cycle later with `rd_valid`=1. In a cycle with no request, the cycle after it has `rd_valid`, `rd_missing`, `rd_underrun` and `rd_data` all at 0. Reset leaves all four at 0.
- R4: After reset the block stays in `ST_IDLE` until the first packet arrives. That packet sets the read position. The block then stays in `ST_FILL` until the number of filled slots reaches `cfg_prefill` (0 counts as 1, values above 16 count as 16). A request answered while waiting returns `rd_missing`=1, `rd_underrun`=1 and data 0.
- R5: In `ST_PLAY`, suppose the slot at the read position is empty when its first byte is requested, but some other slot holds data. Then all bytes of that slot return `rd_missing`=1, `rd_underrun`=0 and data 0, and the read position moves on to the next sequence number.
- R6: In `ST_PLAY`, suppose no slot holds data when a slot's first byte is requested. Then the answer is `rd_missing`=1 and `rd_underrun`=1, the read position does not move, and the block returns to `ST_FILL`.
- R7: A packet is discarded if (seq − read position) mod 65536 is 16 or more. A packet whose number equals the read position is also discarded while that slot is being played, meaning a byte of it has been requested and the slot has not yet finished.
- R8: A packet whose slot already holds data is discarded, and the stored payload is kept.
- R9: With `cfg_reorder_en`=1, a packet older than the newest accepted one but inside the window is placed in its slot. With `cfg_reorder_en`=0, such a packet is discarded. "Newer" means (seq − newest) mod 65536 lies in 1..32767.
- R10: Sequence arithmetic wraps. Number 0x0000 follows 0xFFFF, both for playout order and for the acceptance window.
- R11: Once a slot has been played, it is cleared and can take a packet whose number is 16 higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_reorder_en | input | 1 | 1: place late packets by number; 0: drop packets not newer than the newest |
| cfg_seq_src | input | 1 | 1: sequence number from the RTP field; 0: from the control word field |
| cfg_prefill | input | SLOT_AW+1 | Number of filled slots needed before playout starts |
| wr_valid | input | 1 | A packet is offered this cycle |
| wr_cw_seq | input | SEQ_W | Sequence number from the control word |
| wr_rtp_seq | input | SEQ_W | Sequence number from the RTP header |
| wr_payload | input | PAYLOAD_BYTES*BYTE_W | Packet payload, byte 0 in the low bits |
| rd_req | input | 1 | TDM timeslot tick requesting one byte |
| rd_valid | output | 1 | Answer to the request of the previous cycle |
| rd_data | output | BYTE_W | Played byte, 0 when missing |
| rd_missing | output | 1 | Byte is missing and must be replaced |
| rd_underrun | output | 1 | The missing byte is due to an empty buffer or to waiting for prefill |

## Verification
A behavioural model in the bench mirrors the slot contents, the read position and the state. Every cycle it is compared with the block under several kinds of traffic.

- Packets sent out of order with reordering on show whether late packets are placed by number or by arrival time.
- A sequence with a gap separates a single missing slot from an underrun of the whole buffer.
- Packets far ahead, packets behind, duplicates, and rewrites of the slot being played each exercise one discard rule.
- Traffic across the 0xFFFF boundary shows whether the arithmetic wraps.
- A later packet landing in a slot that was already played shows that the slot is reused.

// File: rtl/sjb_pkg.sv
package sjb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PLAY = 2'd2
    } play_state_e;
endpackage

// File: rtl/sjb_admit.sv
// Acceptance decision for incoming packets: sequence field select, window,
// duplicate, head-lock and late-packet checks, plus newest-number tracking.
module sjb_admit
    import sjb_pkg::*;
#(
    parameter int SEQ_W   = 16,
    parameter int SLOT_AW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_reorder_en,
    input  logic                    cfg_seq_src,
    input  logic                    wr_valid,
    input  logic [SEQ_W-1:0]        wr_cw_seq,
    input  logic [SEQ_W-1:0]        wr_rtp_seq,
    input  play_state_e             play_state,
    input  logic [SEQ_W-1:0]        rd_seq,
    input  logic                    head_locked,
    input  logic [(1<<SLOT_AW)-1:0] filled,
    output logic                    wr_accept,
    output logic                    wr_anchor,
    output logic [SLOT_AW-1:0]      wr_slot,
    output logic [SEQ_W-1:0]        wr_seq
);
    localparam int SLOTS = 1 << SLOT_AW;

    logic [SEQ_W-1:0] seq_sel;
    logic [SEQ_W-1:0] ahead;
    logic [SEQ_W-1:0] lead;
    logic [SEQ_W-1:0] newest_q;
    logic             have_newest_q;
    logic             in_window;
    logic             head_hit;
    logic             is_dup;
    logic             is_newer;
    logic             late_drop;

    always_comb begin
        seq_sel   = cfg_seq_src ? wr_rtp_seq : wr_cw_seq;
        ahead     = seq_sel - rd_seq;
        lead      = seq_sel - newest_q;
        in_window = (ahead < SEQ_W'(SLOTS));
        head_hit  = (ahead == '0) && head_locked;
        is_dup    = filled[seq_sel[SLOT_AW-1:0]];
        is_newer  = (lead != '0) && !lead[SEQ_W-1];
        late_drop = !cfg_reorder_en && have_newest_q && !is_newer;
        wr_anchor = wr_valid && (play_state == ST_IDLE);
        wr_accept = wr_anchor ||
                    (wr_valid && (play_state != ST_IDLE) && in_window &&
                     !head_hit && !is_dup && !late_drop);
        wr_slot   = seq_sel[SLOT_AW-1:0];
        wr_seq    = seq_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            newest_q      <= '0;
            have_newest_q <= 1'b0;
        end else if (wr_accept && (!have_newest_q || is_newer)) begin
            newest_q      <= seq_sel;
            have_newest_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sjb_slot_store.sv
// Payload slots with per-slot filled flags and a filled-slot count.
module sjb_slot_store #(
    parameter int SLOT_AW       = 4,
    parameter int PAYLOAD_BYTES = 4,
    parameter int BYTE_W        = 8,
    parameter int BIDX_W        = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SLOT_AW-1:0]              wr_slot,
    input  logic [PAYLOAD_BYTES*BYTE_W-1:0] wr_payload,
    input  logic                            clr_en,
    input  logic [SLOT_AW-1:0]              clr_slot,
    input  logic [SLOT_AW-1:0]              rd_slot,
    input  logic [BIDX_W-1:0]               rd_idx,
    output logic [BYTE_W-1:0]               rd_byte,
    output logic [(1<<SLOT_AW)-1:0]         filled,
    output logic [SLOT_AW:0]                fill_count
);
    localparam int SLOTS = 1 << SLOT_AW;

    logic [BYTE_W-1:0] mem [SLOTS][PAYLOAD_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < PAYLOAD_BYTES; b++) begin
                mem[wr_slot][b] <= wr_payload[b*BYTE_W +: BYTE_W];
            end
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                filled[s] <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_AW'(s))) begin
                filled[s] <= 1'b1;
            end else if (clr_en && (clr_slot == SLOT_AW'(s))) begin
                filled[s] <= 1'b0;
            end
        end
    end

    always_comb begin
        fill_count = '0;
        for (int s = 0; s < SLOTS; s++) begin
            fill_count = fill_count + (SLOT_AW+1)'(filled[s]);
        end
    end

    assign rd_byte = mem[rd_slot][rd_idx];
endmodule

// File: rtl/sjb_play_fsm.sv
// Playout state machine: read position, byte index, missing/underrun decisions
// and the registered byte answer.
module sjb_play_fsm
    import sjb_pkg::*;
#(
    parameter int SEQ_W         = 16,
    parameter int SLOT_AW       = 4,
    parameter int PAYLOAD_BYTES = 4,
    parameter int BYTE_W        = 8,
    parameter int BIDX_W        = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req,
    input  logic               anchor,
    input  logic [SEQ_W-1:0]   anchor_seq,
    input  logic [SLOT_AW:0]   cfg_prefill,
    input  logic [SLOT_AW:0]   fill_count,
    input  logic               head_filled,
    input  logic [BYTE_W-1:0]  data_in,
    output play_state_e        play_state,
    output logic [SEQ_W-1:0]   rd_seq,
    output logic [BIDX_W-1:0]  rd_idx,
    output logic               head_locked,
    output logic               clr_en,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               rd_missing,
    output logic               rd_underrun
);
    localparam int SLOTS = 1 << SLOT_AW;

    play_state_e       state_q, state_d;
    logic [SEQ_W-1:0]  seq_q, seq_d;
    logic [BIDX_W-1:0] idx_q, idx_d;
    logic              good_q, good_d;
    logic [SLOT_AW:0]  prefill_eff;
    logic              serving;
    logic              at_head;
    logic              last_byte;
    logic              good_now;
    logic              under_now;
    logic              play_byte;

    always_comb begin
        if (cfg_prefill == '0) begin
            prefill_eff = (SLOT_AW+1)'(1);
        end else if (cfg_prefill > (SLOT_AW+1)'(SLOTS)) begin
            prefill_eff = (SLOT_AW+1)'(SLOTS);
        end else begin
            prefill_eff = cfg_prefill;
        end

        serving   = (state_q == ST_PLAY) && rd_req;
        at_head   = (idx_q == '0);
        last_byte = (idx_q == BIDX_W'(PAYLOAD_BYTES-1));
        good_now  = at_head ? head_filled : good_q;
        under_now = at_head && !head_filled && (fill_count == '0);
        play_byte = serving && !under_now && good_now;
        clr_en    = serving && !under_now && last_byte;

        state_d = state_q;
        seq_d   = seq_q;
        idx_d   = idx_q;
        good_d  = good_q;

        unique case (state_q)
            ST_IDLE: begin
                if (anchor) begin
                    state_d = ST_FILL;
                    seq_d   = anchor_seq;
                end
            end
            ST_FILL: begin
                if (fill_count >= prefill_eff) begin
                    state_d = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (serving && under_now) begin
                    state_d = ST_FILL;
                end else if (serving) begin
                    if (at_head) begin
                        good_d = head_filled;
                    end
                    if (last_byte) begin
                        idx_d = '0;
                        seq_d = seq_q + SEQ_W'(1);
                    end else begin
                        idx_d = idx_q + BIDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seq_q   <= '0;
            idx_q   <= '0;
            good_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
            idx_q   <= idx_d;
            good_q  <= good_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            rd_missing  <= 1'b0;
            rd_underrun <= 1'b0;
        end else begin
            rd_valid    <= rd_req;
            rd_data     <= play_byte ? data_in : '0;
            rd_missing  <= rd_req && !play_byte;
            rd_underrun <= rd_req && ((state_q != ST_PLAY) || under_now);
        end
    end

    assign play_state  = state_q;
    assign rd_seq      = seq_q;
    assign rd_idx      = idx_q;
    assign head_locked = (idx_q != '0) || serving;
endmodule

// File: rtl/seq_jitter_buf.sv
module seq_jitter_buf
    import sjb_pkg::*;
#(
    parameter int SEQ_W         = 16,
    parameter int SLOT_AW       = 4,
    parameter int PAYLOAD_BYTES = 4,
    parameter int BYTE_W        = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_reorder_en,
    input  logic                            cfg_seq_src,
    input  logic [SLOT_AW:0]                cfg_prefill,
    input  logic                            wr_valid,
    input  logic [SEQ_W-1:0]                wr_cw_seq,
    input  logic [SEQ_W-1:0]                wr_rtp_seq,
    input  logic [PAYLOAD_BYTES*BYTE_W-1:0] wr_payload,
    input  logic                            rd_req,
    output logic                            rd_valid,
    output logic [BYTE_W-1:0]               rd_data,
    output logic                            rd_missing,
    output logic                            rd_underrun
);
    localparam int SLOTS  = 1 << SLOT_AW;
    localparam int BIDX_W = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1;

    play_state_e         play_state;
    logic [SEQ_W-1:0]    rd_seq;
    logic [BIDX_W-1:0]   rd_idx;
    logic                head_locked;
    logic                clr_en;
    logic [SLOTS-1:0]    filled;
    logic [SLOT_AW:0]    fill_count;
    logic                wr_accept;
    logic                wr_anchor;
    logic [SLOT_AW-1:0]  wr_slot;
    logic [SEQ_W-1:0]    wr_seq;
    logic [BYTE_W-1:0]   store_byte;

    sjb_admit #(.SEQ_W(SEQ_W), .SLOT_AW(SLOT_AW)) u_admit (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_reorder_en (cfg_reorder_en),
        .cfg_seq_src    (cfg_seq_src),
        .wr_valid       (wr_valid),
        .wr_cw_seq      (wr_cw_seq),
        .wr_rtp_seq     (wr_rtp_seq),
        .play_state     (play_state),
        .rd_seq         (rd_seq),
        .head_locked    (head_locked),
        .filled         (filled),
        .wr_accept      (wr_accept),
        .wr_anchor      (wr_anchor),
        .wr_slot        (wr_slot),
        .wr_seq         (wr_seq)
    );

    sjb_slot_store #(
        .SLOT_AW(SLOT_AW), .PAYLOAD_BYTES(PAYLOAD_BYTES),
        .BYTE_W(BYTE_W), .BIDX_W(BIDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_accept),
        .wr_slot    (wr_slot),
        .wr_payload (wr_payload),
        .clr_en     (clr_en),
        .clr_slot   (rd_seq[SLOT_AW-1:0]),
        .rd_slot    (rd_seq[SLOT_AW-1:0]),
        .rd_idx     (rd_idx),
        .rd_byte    (store_byte),
        .filled     (filled),
        .fill_count (fill_count)
    );

    sjb_play_fsm #(
        .SEQ_W(SEQ_W), .SLOT_AW(SLOT_AW), .PAYLOAD_BYTES(PAYLOAD_BYTES),
        .BYTE_W(BYTE_W), .BIDX_W(BIDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .anchor      (wr_anchor),
        .anchor_seq  (wr_seq),
        .cfg_prefill (cfg_prefill),
        .fill_count  (fill_count),
        .head_filled (filled[rd_seq[SLOT_AW-1:0]]),
        .data_in     (store_byte),
        .play_state  (play_state),
        .rd_seq      (rd_seq),
        .rd_idx      (rd_idx),
        .head_locked (head_locked),
        .clr_en      (clr_en),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_missing  (rd_missing),
        .rd_underrun (rd_underrun)
    );
endmodule

// File: rtl/sjb_checker.sv
module sjb_checker
    import sjb_pkg::*;
#(
    parameter int SLOT_AW = 4,
    parameter int BYTE_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [BYTE_W-1:0] rd_data,
    input logic              rd_missing,
    input logic              rd_underrun,
    input play_state_e       play_state,
    input logic [SLOT_AW:0]  fill_count
);
    p_answer_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_quiet_unasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && !rd_missing && !rd_underrun));
    p_waiting_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && play_state != ST_PLAY) |=> (rd_underrun && rd_missing));
    p_play_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_state == ST_PLAY) |-> ($past(fill_count) != '0));
    p_missing_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_missing |-> (rd_data == '0));
    p_underrun_missing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_underrun |-> (rd_missing && rd_valid));
endmodule

bind seq_jitter_buf sjb_checker #(.SLOT_AW(SLOT_AW), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_missing  (rd_missing),
    .rd_underrun (rd_underrun),
    .play_state  (play_state),
    .fill_count  (fill_count)
);

// File: tb/tb_seq_jitter_buf.sv
`timescale 1ns/1ps
module tb_seq_jitter_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_reorder_en = 1'b1;
    logic        cfg_seq_src = 1'b0;
    logic [4:0]  cfg_prefill = 5'd3;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_cw_seq = '0;
    logic [15:0] wr_rtp_seq = '0;
    logic [31:0] wr_payload = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        rd_missing;
    logic        rd_underrun;

    int tests = 0;
    int fails = 0;
    string cur_req = "R3";

    always #5 clk = ~clk;

    seq_jitter_buf dut (
        .clk(clk), .rst_n(rst_n), .cfg_reorder_en(cfg_reorder_en),
        .cfg_seq_src(cfg_seq_src), .cfg_prefill(cfg_prefill),
        .wr_valid(wr_valid), .wr_cw_seq(wr_cw_seq), .wr_rtp_seq(wr_rtp_seq),
        .wr_payload(wr_payload), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_missing(rd_missing), .rd_underrun(rd_underrun)
    );

    function automatic logic [31:0] pl(input int s);
        logic [7:0] b;
        b = 8'(s) ^ 8'h5A;
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    // ---------------- behavioural reference model ----------------
    int         m_state = 0;   // 0 waiting-first, 1 filling, 2 playing
    int         m_rd = 0;
    int         m_byte = 0;
    bit         m_good = 0;
    bit         m_filled [16];
    logic [7:0] m_mem [16][4];
    int         m_newest = 0;
    bit         m_have = 0;
    logic       e_valid = 0, e_miss = 0, e_under = 0;
    logic [7:0] e_data = 0;

    always @(posedge clk) begin
        int seq, ahead, d, cnt, hs, pe;
        bit acc, anchor, locked, serving, good, under, isnewer;
        if (!rst_n) begin
            m_state = 0; m_rd = 0; m_byte = 0; m_good = 0;
            m_newest = 0; m_have = 0;
            foreach (m_filled[i]) m_filled[i] = 0;
            e_valid = 0; e_miss = 0; e_under = 0; e_data = 0;
        end else begin
            seq = cfg_seq_src ? int'(wr_rtp_seq) : int'(wr_cw_seq);
            cnt = 0;
            foreach (m_filled[i]) cnt += m_filled[i];
            locked = (m_byte != 0) || (m_state == 2 && rd_req);
            d = (seq - m_newest) & 'hFFFF;
            isnewer = (d != 0) && (d < 32768);
            acc = 0; anchor = 0;
            if (wr_valid) begin
                if (m_state == 0) begin
                    acc = 1; anchor = 1;
                end else begin
                    ahead = (seq - m_rd) & 'hFFFF;
                    acc = (ahead < 16) && !(ahead == 0 && locked) &&
                          !m_filled[seq % 16] &&
                          !(!cfg_reorder_en && m_have && !isnewer);
                end
            end
            hs = m_rd % 16;
            serving = (m_state == 2) && rd_req;
            good = 0; under = 0;
            if (serving) begin
                if (m_byte == 0) begin
                    good = m_filled[hs];
                    under = !good && (cnt == 0);
                end else begin
                    good = m_good;
                end
            end
            e_valid = rd_req;
            e_data  = (serving && !under && good) ? m_mem[hs][m_byte] : 8'h00;
            e_miss  = rd_req && !(serving && !under && good);
            e_under = rd_req && ((m_state != 2) || under);
            if (serving && !under) begin
                if (m_byte == 0) m_good = good;
                if (m_byte == 3) begin
                    m_filled[hs] = 0;
                    m_rd = (m_rd + 1) & 'hFFFF;
                    m_byte = 0;
                end else begin
                    m_byte++;
                end
            end
            if (acc) begin
                m_filled[seq % 16] = 1;
                for (int b = 0; b < 4; b++) m_mem[seq % 16][b] = wr_payload[b*8 +: 8];
                if (!m_have || isnewer) begin
                    m_newest = seq; m_have = 1;
                end
            end
            pe = (cfg_prefill == 0) ? 1 : ((cfg_prefill > 16) ? 16 : int'(cfg_prefill));
            case (m_state)
                0: if (anchor) begin m_rd = seq; m_state = 1; end
                1: if (cnt >= pe) m_state = 2;
                2: if (serving && under) m_state = 1;
                default: m_state = 0;
            endcase
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        tests++;
        if (rd_valid !== e_valid || rd_data !== e_data ||
            rd_missing !== e_miss || rd_underrun !== e_under) begin
            fails++;
            $display("FAIL %s: got v=%0b d=%02h m=%0b u=%0b expected v=%0b d=%02h m=%0b u=%0b",
                     cur_req, rd_valid, rd_data, rd_missing, rd_underrun,
                     e_valid, e_data, e_miss, e_under);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input bit wv, input int cw, input int rtp,
                       input logic [31:0] p, input bit rq);
        wr_valid   = wv;
        wr_cw_seq  = 16'(cw);
        wr_rtp_seq = 16'(rtp);
        wr_payload = p;
        rd_req     = rq;
        @(negedge clk);
        wr_valid = 1'b0;
        rd_req   = 1'b0;
    endtask

    task automatic send(input int s);
        cyc(1'b1, s, s ^ 'h8000, pl(s), 1'b0);
    endtask

    task automatic sendp(input int s, input logic [31:0] p);
        cyc(1'b1, s, s ^ 'h8000, p, 1'b0);
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, '0, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, '0, 1'b0);
    endtask

    task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, got, exp);
        end
    endtask

    logic [31:0] p109;

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R3", {rd_valid, rd_missing, rd_underrun}, 3'b000);
        rst_n = 1'b1;
        idle(1);

        // R4: waiting before any packet
        cur_req = "R4";
        rd(1);
        chk("R4", {rd_missing, rd_underrun}, 2'b11);
        // R2 / R9: out-of-order arrival with reordering on
        cur_req = "R2";
        send(100);
        rd(1);
        chk("R4", {rd_missing, rd_underrun}, 2'b11);
        send(102);
        cur_req = "R9";
        send(101);
        idle(2);
        cur_req = "R2";
        rd(1);
        chk("R2", {rd_missing, rd_data}, {1'b0, pl(100)[7:0]});
        rd(3);
        chk("R2", rd_data, pl(100)[31:24]);
        rd(4);
        chk("R9", rd_data, pl(101)[31:24]);
        rd(4);

        // R5: gap at 104
        cur_req = "R5";
        send(103);
        send(105);
        rd(4);
        rd(1);
        chk("R5", {rd_missing, rd_underrun}, 2'b10);
        rd(3);
        rd(4);
        chk("R5", rd_data, pl(105)[31:24]);

        // R6: empty buffer
        cur_req = "R6";
        rd(1);
        chk("R6", {rd_missing, rd_underrun}, 2'b11);
        send(106); send(107); send(108);
        idle(2);

        // R7: window discards
        cur_req = "R7";
        send(130);
        send(105);
        rd(1);
        chk("R6", rd_data, pl(106)[7:0]);
        rd(11);
        send(109); send(110);
        rd(1);
        p109 = ~pl(109);
        sendp(109, p109);
        rd(3);
        chk("R7", rd_data, pl(109)[31:24]);

        // R8: duplicate keeps original
        cur_req = "R8";
        send(111);
        sendp(111, ~pl(111));
        rd(4);
        rd(1);
        chk("R8", rd_data, pl(111)[7:0]);
        rd(3);

        // R9: reordering off drops late 112
        cur_req = "R9";
        cfg_reorder_en = 1'b0;
        send(113);
        send(112);
        rd(1);
        chk("R9", {rd_missing, rd_underrun}, 2'b10);
        rd(7);

        // R1: RTP field select
        cur_req = "R1";
        cfg_seq_src = 1'b1;
        cyc(1'b1, 500, 114, pl(114), 1'b0);
        cyc(1'b1, 115, 900, pl(115), 1'b0);
        rd(1);
        chk("R1", rd_data, pl(114)[7:0]);
        rd(3);
        rd(1);
        chk("R1", {rd_missing, rd_underrun}, 2'b11);
        cfg_seq_src = 1'b0;
        cfg_reorder_en = 1'b1;

        // R10 / R11: wraparound and slot reuse, prefill 0 treated as 1
        cur_req = "R10";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        cfg_prefill = 5'd0;
        send('hFFFE);
        send('hFFFF);
        send('h0000);
        idle(1);
        rd(4);
        rd(1);
        chk("R10", rd_data, pl('hFFFF)[7:0]);
        rd(3);
        rd(4);
        chk("R10", rd_data, pl('h0000)[31:24]);
        cur_req = "R11";
        send('h000E);
        send('h0020);
        rd(13 * 4);
        rd(1);
        chk("R11", {rd_missing, rd_data}, {1'b0, pl('h000E)[7:0]});
        rd(3);
        idle(2);

        // R4: prefill above slot count treated as 16
        cur_req = "R4";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        cfg_prefill = 5'd31;
        for (int s = 0; s < 16; s++) send(40 + s);
        idle(1);
        rd(1);
        chk("R4", {rd_missing, rd_data}, {1'b0, pl(40)[7:0]});
        rd(7);
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule